// File: doc/BRIEF.md
# Serial Port with Slave-Address Filtering

This block is a full-duplex asynchronous serial port that a processor drives through a small byte-wide register file. It sends and receives either plain 10-bit frames or 11-bit frames that carry a ninth bit. The ninth bit marks address frames on a shared multi-drop line.

The receiver oversamples its line with a tick at 16 times the bit rate. It votes on each bit and applies an acceptance rule before anything reaches software. When multiprocessor filtering is on, an address frame is kept only if its byte equals this node's masked own address or its broadcast address. Every other frame is dropped without raising the receive flag.

The transmitter serialises one frame per write to the data register, advancing one bit per transmit tick. Both tick inputs come from a baud generator outside the block.

Top module: `uart_ap_top`

## Requirements
- R1: Plain-frame reception (mode bit, control bit 7, at 0). The frame is a 0 start bit, then 8 data bits with the least significant bit first, then a stop bit. On acceptance the byte goes to register 0 and the sampled stop bit goes to the received-ninth-bit field (control bit 2).
- R2: Nine-bit reception (mode bit at 1). The frame is start, 8 data bits least significant first, a ninth bit, then stop. On acceptance the ninth bit goes to control bit 2.
- R3: Reception is enabled by control bit 4. A frame starts on a 1-to-0 change of the line between two consecutive oversample ticks. Each bit is the majority of three samples taken at ticks 7, 8 and 9 of its 16-tick period, so a one-tick spike inside a bit has no effect. A start bit whose vote is 1 is abandoned and sets no flag.
- R4: A completed frame loads register 0 and control bit 2 and sets the receive flag (control bit 0) only if two conditions hold. The receive flag must be clear, and either the filter enable (control bit 5) is 0 or the received ninth bit is 1. Otherwise the frame is discarded and the register 0, bit 2 and bit 0 keep their values.
- R5: In nine-bit mode with the filter enabled, the byte must also match. It matches the given address when (byte XOR address) AND mask is 0, with the address in register 2 and the mask in register 3. It matches the broadcast address when every bit set in (address OR mask) is also set in the byte.
- R6: A stop bit sampled as 0 sets a framing-error flag, whether or not the frame is accepted. The flag stays set until software writes 0 to it. While the report bit (register 4, bit 0) is 1, control bit 7 reads and writes this flag instead of the mode bit.
- R7: A write to register 0 while the transmitter is idle starts a frame. Each later transmit tick drives the next bit on the line: start 0, data least significant first, then control bit 3 in nine-bit mode, then stop 1. One further tick ends the frame. The line is 1 when idle, and writes to register 0 during a frame are ignored.
- R8: The transmit flag (control bit 1) is set on the tick that starts the stop bit. It stays set until software writes it to 0.
- R9: After reset the line output is 1 and every register, including the read port, is 0.
- R10: The read port is registered. One cycle after a register index is presented, it shows that register: 0 the received byte, 1 control, 2 address, 3 mask, 4 report enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rx_tick | input | 1 | Receive oversample tick, 16 per bit |
| tx_tick | input | 1 | Transmit bit tick |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench aims at the acceptance rule, which is where a wrong design fails quietly. Its cases are an address frame matching only through a mask don't-care bit, a broadcast match, a near miss that must be dropped, a data frame that must be dropped under filtering, and a frame arriving while the receive flag is still set. A design that got any of these wrong would let a foreign frame overwrite the buffer, or lose a frame meant for it.

A start-bit spike and a one-tick spike inside a data bit are also driven. A receiver without proper voting would decode garbage or lock onto noise.

On the transmit side, the bench checks the ticks at which the flag rises and a write made during a frame. A bad design would flag a bit early or corrupt the frame in flight.

// File: rtl/uart_ap_pkg.sv
package uart_ap_pkg;
  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_ADDR = 3'd2;
  localparam logic [2:0] REG_MASK = 3'd3;
  localparam logic [2:0] REG_AUX  = 3'd4;

  localparam int C_RXF  = 0;
  localparam int C_TXF  = 1;
  localparam int C_RB9  = 2;
  localparam int C_TB9  = 3;
  localparam int C_REN  = 4;
  localparam int C_MPE  = 5;
  localparam int C_TOP  = 7;
endpackage

// File: rtl/uart_ap_match.sv
module uart_ap_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] own_mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          given_hit;
  logic          bcast_hit;

  always_comb begin
    bcast     = own_addr | own_mask;
    given_hit = (((byte_in ^ own_addr) & own_mask) == '0);
    bcast_hit = ((byte_in & bcast) == bcast);
    hit       = given_hit | bcast_hit;
  end
endmodule

// File: rtl/uart_ap_rx.sv
module uart_ap_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          mode9,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok
);
  localparam int PW  = $clog2(OSR);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OSR / 2;
  localparam logic [PW-1:0] S0   = PW'(MID - 1);
  localparam logic [PW-1:0] S1   = PW'(MID);
  localparam logic [PW-1:0] S2   = PW'(MID + 1);
  localparam logic [PW-1:0] PEND = PW'(OSR - 1);

  logic          sy1, sy2, last_s, running, m9q, v0, v1, vote;
  logic [PW-1:0] ph;
  logic [IW-1:0] idx, last_idx;
  logic [DW:0]   sh;

  always_comb begin
    vote     = (v0 & v1) | (v0 & sy2) | (v1 & sy2);
    last_idx = m9q ? IW'(DW + 2) : IW'(DW + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= 1'b1; sy2 <= 1'b1; last_s <= 1'b1;
      running <= 1'b0; m9q <= 1'b0; v0 <= 1'b0; v1 <= 1'b0;
      ph <= '0; idx <= '0; sh <= '0;
      done <= 1'b0; data <= '0; bit9 <= 1'b0; stop_ok <= 1'b0;
    end else begin
      sy1  <= rxd;
      sy2  <= sy1;
      done <= 1'b0;
      if (tick) begin
        last_s <= sy2;
        if (!running) begin
          if (en && last_s && !sy2) begin
            running <= 1'b1;
            m9q     <= mode9;
            ph      <= '0;
            idx     <= '0;
          end
        end else begin
          ph <= (ph == PEND) ? '0 : ph + 1'b1;
          if (ph == PEND) idx <= idx + 1'b1;
          if (ph == S0) v0 <= sy2;
          if (ph == S1) v1 <= sy2;
          if (ph == S2) begin
            if (idx == '0) begin
              if (vote) running <= 1'b0;
            end else if (idx == last_idx) begin
              running <= 1'b0;
              done    <= 1'b1;
              stop_ok <= vote;
              if (m9q) begin
                data <= sh[DW-1:0];
                bit9 <= sh[DW];
              end else begin
                data <= sh[DW:1];
                bit9 <= vote;
              end
            end else begin
              sh <= {vote, sh[DW:1]};
            end
          end
        end
      end
    end
  end

  a_r3_done_ends_frame: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(running));
  a_r3_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!running && !en) |=> !running);
endmodule

// File: rtl/uart_ap_tx.sv
module uart_ap_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          b9,
  input  logic          mode9,
  output logic          txd,
  output logic          busy,
  output logic          stop_start
);
  localparam int CW = $clog2(DW + 4);

  logic [DW+2:0] sh;
  logic [CW-1:0] cnt, nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1; cnt <= '0; nbits <= '0;
      txd <= 1'b1; busy <= 1'b0; stop_start <= 1'b0;
    end else begin
      stop_start <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy  <= 1'b1;
          cnt   <= '0;
          sh    <= {1'b1, (mode9 ? b9 : 1'b1), din, 1'b0};
          nbits <= mode9 ? CW'(DW + 3) : CW'(DW + 2);
        end
      end else if (tick) begin
        if (cnt < nbits) begin
          txd <= sh[0];
          sh  <= {1'b1, sh[DW+2:1]};
          cnt <= cnt + 1'b1;
          if (cnt == nbits - 1'b1) stop_start <= 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  a_r8_flag_on_stop: assert property (@(posedge clk) disable iff (rst)
    stop_start |-> (txd && busy));
endmodule

// File: rtl/uart_ap_top.sv
module uart_ap_top
  import uart_ap_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rx_tick,
  input  logic          tx_tick,
  input  logic          rxd,
  output logic          txd
);
  logic          rx_flag, tx_flag, rx_b9, tx_b9, rx_en, mp_en, mode9, fe, fe_rep;
  logic [DW-1:0] rx_buf, own_addr, own_mask;
  logic          rx_done, rx_bit9, rx_stop, hit, accept, ctrl_wr, tx_load;
  logic          tx_busy, tx_stop;
  logic [DW-1:0] rx_byte, ctrl_view;

  uart_ap_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .rxd(rxd), .en(rx_en), .mode9(mode9),
    .done(rx_done), .data(rx_byte), .bit9(rx_bit9), .stop_ok(rx_stop));

  uart_ap_match #(.DW(DW)) u_match (
    .byte_in(rx_byte), .own_addr(own_addr), .own_mask(own_mask), .hit(hit));

  uart_ap_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .load(tx_load), .din(wr_data),
    .b9(tx_b9), .mode9(mode9), .txd(txd), .busy(tx_busy), .stop_start(tx_stop));

  always_comb begin
    ctrl_wr = wr_en && (reg_addr == REG_CTRL);
    tx_load = wr_en && (reg_addr == REG_DATA);
    accept  = !rx_flag && (!mp_en || (rx_bit9 && (!mode9 || hit)));
    ctrl_view = '0;
    ctrl_view[C_RXF] = rx_flag;
    ctrl_view[C_TXF] = tx_flag;
    ctrl_view[C_RB9] = rx_b9;
    ctrl_view[C_TB9] = tx_b9;
    ctrl_view[C_REN] = rx_en;
    ctrl_view[C_MPE] = mp_en;
    ctrl_view[C_TOP] = fe_rep ? fe : mode9;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag <= 1'b0; tx_flag <= 1'b0; rx_b9 <= 1'b0; tx_b9 <= 1'b0;
      rx_en <= 1'b0; mp_en <= 1'b0; mode9 <= 1'b0; fe <= 1'b0; fe_rep <= 1'b0;
      rx_buf <= '0; own_addr <= '0; own_mask <= '0; rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (reg_addr)
          REG_CTRL: begin
            rx_flag <= wr_data[C_RXF];
            tx_flag <= wr_data[C_TXF];
            rx_b9   <= wr_data[C_RB9];
            tx_b9   <= wr_data[C_TB9];
            rx_en   <= wr_data[C_REN];
            mp_en   <= wr_data[C_MPE];
            if (fe_rep) fe <= wr_data[C_TOP];
            else        mode9 <= wr_data[C_TOP];
          end
          REG_ADDR: own_addr <= wr_data;
          REG_MASK: own_mask <= wr_data;
          REG_AUX:  fe_rep   <= wr_data[0];
          default: ;
        endcase
      end
      if (rx_done) begin
        if (!rx_stop) fe <= 1'b1;
        if (accept) begin
          rx_buf  <= rx_byte;
          rx_b9   <= rx_bit9;
          rx_flag <= 1'b1;
        end
      end
      if (tx_stop) tx_flag <= 1'b1;
      case (reg_addr)
        REG_DATA: rd_data <= rx_buf;
        REG_CTRL: rd_data <= ctrl_view;
        REG_ADDR: rd_data <= own_addr;
        REG_MASK: rd_data <= own_mask;
        REG_AUX:  rd_data <= {{(DW-1){1'b0}}, fe_rep};
        default:  rd_data <= '0;
      endcase
    end
  end

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !ctrl_wr) |=> rx_flag);
  a_r4_buffer_held: assert property (@(posedge clk) disable iff (rst)
    rx_flag |=> $stable(rx_buf));
  a_r6_fe_sticky: assert property (@(posedge clk) disable iff (rst)
    (fe && !ctrl_wr) |=> fe);
  a_r8_txflag_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_flag && !ctrl_wr) |=> tx_flag);
endmodule

// File: tb/uart_ap_top_test.sv
`timescale 1ns/1ps
module uart_ap_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       rx_tick = 1'b0;
  logic       tx_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  int checks = 0;
  int fails  = 0;

  uart_ap_top uut (.clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .rxd(rxd), .txd(txd));

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    rx_tick = ~rx_tick;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stp, input logic m9);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (m9) hold_bit(b9);
    hold_bit(stp);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  function automatic logic addr_ok(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
    logic [7:0] b;
    b = a | m;
    return (((d ^ a) & m) == 8'h00) || ((d & b) == b);
  endfunction

  function automatic logic acc(input logic flag, input logic mp, input logic m9,
                               input logic [7:0] d, input logic b9,
                               input logic [7:0] a, input logic [7:0] m);
    return !flag && (!mp || (b9 && (!m9 || addr_ok(d, a, m))));
  endfunction

  function automatic logic [7:0] ctrl(input logic m9, input logic mp, input logic tb9);
    return {m9, 1'b0, mp, 1'b1, tb9, 3'b000};
  endfunction

  task automatic tx_tick1;
    @(negedge clk); tx_tick = 1'b1;
    @(negedge clk); tx_tick = 1'b0;
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic m9, input logic tb9);
    logic [10:0] bits;
    logic [7:0]  r;
    int n;
    n = m9 ? 11 : 10;
    bits = m9 ? {1'b1, tb9, d, 1'b0} : {1'b1, 1'b1, d, 1'b0};
    wr(3'd1, ctrl(m9, 1'b0, tb9));
    wr(3'd0, d);
    for (int i = 0; i < n; i++) begin
      tx_tick1();
      chk("R7 txd bit", {7'd0, txd}, {7'd0, bits[i]});
      if (i == 1) wr(3'd0, ~d);
      if (i == n - 2) begin
        rd(3'd1, r);
        chk("R8 tx flag before stop", {7'd0, r[1]}, 8'd0);
      end
    end
    rd(3'd1, r);
    chk("R8 tx flag at stop", {7'd0, r[1]}, 8'd1);
    tx_tick1();
    chk("R7 idle after frame", {7'd0, txd}, 8'd1);
  endtask

  initial begin
    logic [7:0] r, d, a, m, ebuf;
    logic eflag, eb9, m9, mp, b9, ok;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 txd idle", {7'd0, txd}, 8'd1);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), r);
      chk("R9 reg zero", r, 8'd0);
    end
    // R10 register map readback
    wr(3'd2, 8'hC0); wr(3'd3, 8'hFD);
    rd(3'd2, r); chk("R10 address reg", r, 8'hC0);
    rd(3'd3, r); chk("R10 mask reg", r, 8'hFD);
    // R1 plain frame
    wr(3'd1, ctrl(1'b0, 1'b0, 1'b0));
    send(8'hA5, 1'b0, 1'b1, 1'b0);
    rd(3'd0, r); chk("R1 data", r, 8'hA5);
    rd(3'd1, r); chk("R1 flag+stop bit", r[2:0], 3'b101);
    // R4 flag set blocks next frame
    send(8'h3C, 1'b0, 1'b1, 1'b0);
    rd(3'd0, r); chk("R4 buffer kept while flag set", r, 8'hA5);
    // R3 one-tick spike inside data bit ignored by vote
    wr(3'd1, ctrl(1'b0, 1'b0, 1'b0));
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      rxd = (8'h5A >> i) & 1;
      repeat (18) @(negedge clk);
      if (i == 3) rxd = ~rxd;
      repeat (2) @(negedge clk);
      rxd = (8'h5A >> i) & 1;
      repeat (12) @(negedge clk);
    end
    hold_bit(1'b1);
    repeat (40) @(negedge clk);
    rd(3'd0, r); chk("R3 spike rejected by vote", r, 8'h5A);
    // R3 start glitch
    wr(3'd1, ctrl(1'b0, 1'b0, 1'b0));
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    rd(3'd1, r); chk("R3 glitch sets no flag", {7'd0, r[0]}, 8'd0);
    // R3 receiver disabled
    wr(3'd1, 8'h00);
    send(8'h11, 1'b0, 1'b1, 1'b0);
    rd(3'd1, r); chk("R3 disabled receiver", {7'd0, r[0]}, 8'd0);
    // R6 framing error, reported through top bit
    wr(3'd1, ctrl(1'b0, 1'b0, 1'b0));
    send(8'h77, 1'b0, 1'b0, 1'b0);
    wr(3'd4, 8'h01);
    rd(3'd1, r); chk("R6 fe set", {7'd0, r[7]}, 8'd1);
    rd(3'd0, r); chk("R6 data still accepted", r, 8'h77);
    wr(3'd1, 8'h90);
    rd(3'd1, r); chk("R6 fe stays until cleared", {7'd0, r[7]}, 8'd1);
    wr(3'd1, 8'h10);
    rd(3'd1, r); chk("R6 fe cleared", {7'd0, r[7]}, 8'd0);
    wr(3'd4, 8'h00);
    rd(3'd1, r); chk("R6 mode bit visible again", {7'd0, r[7]}, 8'd0);
    // R4 filter in plain mode: bad stop dropped
    wr(3'd1, ctrl(1'b0, 1'b1, 1'b0));
    send(8'h22, 1'b0, 1'b0, 1'b0);
    rd(3'd1, r); chk("R4 mp stop0 dropped", {7'd0, r[0]}, 8'd0);
    // R2/R5 nine-bit address frames, address C0 mask FD
    wr(3'd1, ctrl(1'b1, 1'b1, 1'b0));
    send(8'hC2, 1'b1, 1'b1, 1'b1);
    rd(3'd0, r); chk("R5 given match with dont-care", r, 8'hC2);
    rd(3'd1, r); chk("R2 ninth bit stored", r[2:0], 3'b101);
    wr(3'd1, ctrl(1'b1, 1'b1, 1'b0));
    send(8'hC4, 1'b1, 1'b1, 1'b1);
    rd(3'd1, r); chk("R5 mismatch dropped", {7'd0, r[0]}, 8'd0);
    send(8'hFF, 1'b1, 1'b1, 1'b1);
    rd(3'd0, r); chk("R5 broadcast match", r, 8'hFF);
    wr(3'd1, ctrl(1'b1, 1'b1, 1'b0));
    send(8'hC0, 1'b0, 1'b1, 1'b1);
    rd(3'd1, r); chk("R4 data frame dropped under filter", {7'd0, r[0]}, 8'd0);
    wr(3'd1, ctrl(1'b1, 1'b0, 1'b0));
    send(8'h31, 1'b0, 1'b1, 1'b1);
    rd(3'd0, r); chk("R2 data frame no filter", r, 8'h31);
    rd(3'd1, r); chk("R2 ninth bit zero", r[2:0], 3'b001);
    // random frames against the model
    ebuf = 8'h31; eb9 = 1'b0; eflag = 1'b1;
    for (int k = 0; k < 30; k++) begin
      m9 = 1'($urandom); mp = 1'($urandom);
      a = 8'($urandom); m = 8'($urandom);
      case ($urandom % 3)
        0: d = a ^ (8'($urandom) & ~m);
        1: d = (a | m) | 8'($urandom);
        default: d = 8'($urandom);
      endcase
      b9 = m9 ? 1'($urandom) : 1'b1;
      if (($urandom % 4) != 0) eflag = 1'b0;
      wr(3'd2, a); wr(3'd3, m);
      wr(3'd1, ctrl(m9, mp, 1'b0) | {5'd0, eb9, 1'b0, eflag});
      ok = acc(eflag, mp, m9, d, b9, a, m);
      send(d, b9, 1'b1, m9);
      if (ok) begin ebuf = d; eb9 = b9; eflag = 1'b1; end
      rd(3'd0, r); chk("R5 random buffer", r, ebuf);
      rd(3'd1, r); chk("R4 random flag/bit9", {5'd0, r[2:0]}, {5'd0, eb9, 1'b0, eflag});
    end
    // R7/R8 transmit
    tx_frame(8'hB3, 1'b0, 1'b0);
    tx_frame(8'h4E, 1'b1, 1'b0);
    tx_frame(8'h01, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) tx_frame(8'($urandom), 1'($urandom), 1'($urandom));
    wr(3'd1, 8'h10);
    rd(3'd1, r); chk("R8 tx flag cleared", {7'd0, r[1]}, 8'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule